// File: doc/BRIEF.md
# Frame-Rate Pixel Blink Unit

This block makes selected pixels of a video stream blink. A single blink phase bit is shared by every pixel. It flips after a programmable number of frame-start pulses. Each incoming pixel carries a sideband flag that marks it as blinking. A marked pixel is rewritten only while the phase bit is high. Every other pixel leaves the block unchanged.

The rewrite has two forms. In palette modes (4 and 8 bits per pixel), the pixel's low bits are a colour-table index. That index is combined with a mask using AND, OR or XOR, so that a blinking entry points at an alternate table slot. In true-colour modes (16 and 24 bits per pixel), a bypass control skips the index path. The 24-bit colour is then changed directly in one of four ways: replace it with a background colour, halve it, brighten it, or add an offset colour. The colour table itself lies outside this block. The output is registered, with one cycle of latency.

Top module: `blink_pixel_unit`

## Requirements
- R1: While `rst` is high, on each clock `blink_on` and `pix_out` become 0.
- R2: With `cfg_rate` = N (N > 0), `blink_on` inverts on the clock where `frame_start` is seen for the N-th time since the last inversion, or since reset or a zero rate.
- R3: While `cfg_rate` is 0, `blink_on` is 0 from the next clock on, the frame count is cleared, and `frame_start` has no effect.
- R4: `blink_on` keeps its value on any clock where `frame_start` is low and `cfg_rate` is nonzero.
- R5: A pixel with `pix_blink` low, or any pixel while `blink_on` is 0, appears unchanged on `pix_out` one clock later.
- R6: With `cfg_bypass` = 0, a blinking pixel in the blink phase has its low ADDR_W bits combined with `cfg_mask`. `cfg_op` selects the operation: 0 = AND, 1 = OR, 2 = XOR, 3 = unchanged. The bits above ADDR_W pass through unchanged. For example, index 0x11 XOR mask 0x30 gives 0x21.
- R7: With `cfg_bypass` = 1 and `cfg_op` = 0, a blinking pixel in the blink phase is replaced by `cfg_bkgnd`.
- R8: With `cfg_bypass` = 1 and `cfg_op` = 1, each 8-bit channel is shifted right by one. The channels are bits 23:16, 15:8 and 7:0.
- R9: With `cfg_bypass` = 1 and `cfg_op` = 2, each channel c becomes c + (c >> 1), limited to 0xFF.
- R10: With `cfg_bypass` = 1 and `cfg_op` = 3, each channel becomes the channel plus the matching channel of `cfg_bkgnd`, limited to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-clock pulse at the start of each video frame |
| cfg_rate | input | RATE_W (8) | Frames per blink half-period; 0 disables blinking |
| cfg_bypass | input | 1 | 0 = colour-table index path, 1 = direct colour path |
| cfg_op | input | 2 | Operation select for the active path |
| cfg_mask | input | ADDR_W (8) | Mask for the index rewrite |
| cfg_bkgnd | input | 24 | Background or offset colour |
| pix_in | input | 24 | Incoming pixel word |
| pix_blink | input | 1 | Sideband flag marking the pixel as blinking |
| pix_out | output | 24 | Registered result pixel |
| blink_on | output | 1 | Shared blink phase bit |

## Verification
On every clock, the assertions check four things:
- the phase bit never moves without a frame pulse, and is cleared under a zero rate;
- unmarked pixels and pixels outside the blink phase pass through exactly, one clock later;
- the index path never touches the bits above the index;
- the brighten and offset modes never wrap a channel below its input.

Only the bench's scenarios can show the rest. These are the exact toggle point after N pulses, the specific AND, OR and XOR results, and the saturation values such as 0xFF staying 0xFF and 0x80 becoming 0xC0. They also cover changing the rate during a run.

// File: rtl/blink_pkg.sv
package blink_pkg;
    localparam int CH_W    = 8;
    localparam int N_CH    = 3;
    localparam int PIX_W   = CH_W * N_CH;

    typedef logic [N_CH-1:0][CH_W-1:0] rgb_t;

    typedef enum logic [1:0] {
        IDX_AND  = 2'd0,
        IDX_OR   = 2'd1,
        IDX_XOR  = 2'd2,
        IDX_KEEP = 2'd3
    } idx_op_e;

    typedef enum logic [1:0] {
        CLR_BKGND  = 2'd0,
        CLR_DIM    = 2'd1,
        CLR_BRIGHT = 2'd2,
        CLR_OFFSET = 2'd3
    } clr_op_e;

    function automatic logic [CH_W-1:0] sat_add(input logic [CH_W-1:0] a,
                                                input logic [CH_W-1:0] b);
        logic [CH_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CH_W] ? {CH_W{1'b1}} : s[CH_W-1:0];
    endfunction
endpackage

// File: rtl/blink_frame_timer.sv
module blink_frame_timer #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [RATE_W-1:0] rate,
    output logic              blink_on
);
    logic [RATE_W-1:0] frame_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_cnt <= '0;
            blink_on  <= 1'b0;
        end else if (rate == '0) begin
            frame_cnt <= '0;
            blink_on  <= 1'b0;
        end else if (frame_start) begin
            if (frame_cnt >= rate - RATE_W'(1)) begin
                frame_cnt <= '0;
                blink_on  <= ~blink_on;
            end else begin
                frame_cnt <= frame_cnt + RATE_W'(1);
            end
        end
    end

    assert_phase_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && rate != '0) |=> $stable(blink_on));

    assert_zero_rate_R3: assert property (@(posedge clk) disable iff (rst)
        (rate == '0) |=> !blink_on);
endmodule

// File: rtl/blink_index_xform.sv
module blink_index_xform
    import blink_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] idx_in,
    input  logic [ADDR_W-1:0] mask,
    input  logic [1:0]        op,
    output logic [ADDR_W-1:0] idx_out
);
    always_comb begin
        unique case (idx_op_e'(op))
            IDX_AND:  idx_out = idx_in & mask;
            IDX_OR:   idx_out = idx_in | mask;
            IDX_XOR:  idx_out = idx_in ^ mask;
            default:  idx_out = idx_in;
        endcase
    end
endmodule

// File: rtl/blink_color_xform.sv
module blink_color_xform
    import blink_pkg::*;
(
    input  rgb_t       color_in,
    input  rgb_t       bkgnd,
    input  logic [1:0] op,
    output rgb_t       color_out
);
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic [CH_W-1:0] c;
        assign c = color_in[ch];
        always_comb begin
            unique case (clr_op_e'(op))
                CLR_BKGND:  color_out[ch] = bkgnd[ch];
                CLR_DIM:    color_out[ch] = c >> 1;
                CLR_BRIGHT: color_out[ch] = sat_add(c, c >> 1);
                default:    color_out[ch] = sat_add(c, bkgnd[ch]);
            endcase
        end
    end
endmodule

// File: rtl/blink_pixel_unit.sv
module blink_pixel_unit
    import blink_pkg::*;
#(
    parameter int RATE_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic              cfg_bypass,
    input  logic [1:0]        cfg_op,
    input  logic [ADDR_W-1:0] cfg_mask,
    input  logic [PIX_W-1:0]  cfg_bkgnd,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic              pix_blink,
    output logic [PIX_W-1:0]  pix_out,
    output logic              blink_on
);
    logic [ADDR_W-1:0] idx_new;
    rgb_t              clr_new;
    logic [PIX_W-1:0]  pix_next;

    blink_frame_timer #(.RATE_W(RATE_W)) u_timer (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .rate(cfg_rate), .blink_on(blink_on)
    );

    blink_index_xform #(.ADDR_W(ADDR_W)) u_idx (
        .idx_in(pix_in[ADDR_W-1:0]), .mask(cfg_mask),
        .op(cfg_op), .idx_out(idx_new)
    );

    blink_color_xform u_clr (
        .color_in(rgb_t'(pix_in)), .bkgnd(rgb_t'(cfg_bkgnd)),
        .op(cfg_op), .color_out(clr_new)
    );

    always_comb begin
        pix_next = pix_in;
        if (pix_blink && blink_on) begin
            if (cfg_bypass) pix_next = PIX_W'(clr_new);
            else            pix_next[ADDR_W-1:0] = idx_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pix_out <= '0;
        else     pix_out <= pix_next;
    end

    assert_passthru_R5: assert property (@(posedge clk) disable iff (rst)
        (!pix_blink || !blink_on) |=> pix_out == $past(pix_in));

    assert_upper_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_bypass) |=> pix_out[PIX_W-1:ADDR_W] == $past(pix_in[PIX_W-1:ADDR_W]));

    assert_bright_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_bypass && cfg_op == 2'd2 && pix_blink && blink_on) |=>
        (pix_out[23:16] >= $past(pix_in[23:16]) &&
         pix_out[15:8]  >= $past(pix_in[15:8])  &&
         pix_out[7:0]   >= $past(pix_in[7:0])));

    assert_offset_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_bypass && cfg_op == 2'd3 && pix_blink && blink_on) |=>
        (pix_out[23:16] >= $past(pix_in[23:16]) &&
         pix_out[15:8]  >= $past(pix_in[15:8])  &&
         pix_out[7:0]   >= $past(pix_in[7:0])));
endmodule

// File: tb/blink_pixel_unit_test.sv
module blink_pixel_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic [7:0]  cfg_rate = 8'd0;
    logic        cfg_bypass = 1'b0;
    logic [1:0]  cfg_op = 2'd0;
    logic [7:0]  cfg_mask = 8'd0;
    logic [23:0] cfg_bkgnd = 24'd0;
    logic [23:0] pix_in = 24'd0;
    logic        pix_blink = 1'b0;
    logic [23:0] pix_out;
    logic        blink_on;

    int n_chk = 0;
    int n_bad = 0;
    int m_cnt = 0;
    bit m_state = 1'b0;

    always #5 clk = ~clk;

    blink_pixel_unit uut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .cfg_rate(cfg_rate),
        .cfg_bypass(cfg_bypass), .cfg_op(cfg_op), .cfg_mask(cfg_mask),
        .cfg_bkgnd(cfg_bkgnd), .pix_in(pix_in), .pix_blink(pix_blink),
        .pix_out(pix_out), .blink_on(blink_on)
    );

    function automatic logic [7:0] csat(input int v);
        return (v > 255) ? 8'hFF : v[7:0];
    endfunction

    function automatic logic [23:0] model_pix(input logic [23:0] p, input bit bl,
                                              input bit st, input bit byp,
                                              input logic [1:0] op,
                                              input logic [7:0] msk,
                                              input logic [23:0] bg);
        logic [23:0] r;
        r = p;
        if (bl && st) begin
            if (!byp) begin
                case (op)
                    2'd0: r[7:0] = p[7:0] & msk;
                    2'd1: r[7:0] = p[7:0] | msk;
                    2'd2: r[7:0] = p[7:0] ^ msk;
                    default: r = p;
                endcase
            end else begin
                for (int k = 0; k < 3; k++) begin
                    int c, b;
                    c = int'(p[k*8 +: 8]);
                    b = int'(bg[k*8 +: 8]);
                    case (op)
                        2'd0: r[k*8 +: 8] = bg[k*8 +: 8];
                        2'd1: r[k*8 +: 8] = 8'(c / 2);
                        2'd2: r[k*8 +: 8] = csat(c + c / 2);
                        default: r[k*8 +: 8] = csat(c + b);
                    endcase
                end
            end
        end
        return r;
    endfunction

    function automatic string req_of(input bit bl, input bit st, input bit byp,
                                     input logic [1:0] op);
        if (!(bl && st)) return "R5";
        if (!byp)        return "R6";
        case (op)
            2'd0: return "R7";
            2'd1: return "R8";
            2'd2: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string rq, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %06h expected %06h", rq, act, exp);
        end
    endtask

    // drive at negedge, one rising edge, sample at the following negedge
    task automatic step(input bit fs, input bit bl, input logic [23:0] p);
        logic [23:0] exp_pix;
        string rq;
        frame_start = fs;
        pix_blink = bl;
        pix_in = p;
        exp_pix = model_pix(p, bl, m_state, cfg_bypass, cfg_op, cfg_mask, cfg_bkgnd);
        rq = req_of(bl, m_state, cfg_bypass, cfg_op);
        if (cfg_rate == 8'd0) begin
            m_cnt = 0;
            m_state = 1'b0;
        end else if (fs) begin
            if (m_cnt + 1 >= int'(cfg_rate)) begin
                m_cnt = 0;
                m_state = !m_state;
            end else begin
                m_cnt++;
            end
        end
        @(negedge clk);
        check(rq, pix_out, exp_pix);
        check((cfg_rate == 0) ? "R3" : "R2", {23'd0, blink_on}, {23'd0, m_state});
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        @(negedge clk);
        check("R1", pix_out, 24'd0);
        check("R1", {23'd0, blink_on}, 24'd0);
        rst = 1'b0;

        // R3: zero rate ignores frame pulses
        cfg_rate = 8'd0; cfg_bypass = 1'b0; cfg_op = 2'd2; cfg_mask = 8'h30;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 24'hABCD11);

        // R2: rate 3, toggle on third pulse; R4 idle clocks in between
        cfg_rate = 8'd3;
        step(1'b1, 1'b0, 24'h000001);
        step(1'b0, 1'b0, 24'h000002);
        step(1'b1, 1'b0, 24'h000003);
        step(1'b1, 1'b0, 24'h000004);
        check("R2", {23'd0, blink_on}, 24'd1);
        // R6: 0x11 XOR 0x30 -> 0x21, upper bits kept
        step(1'b0, 1'b1, 24'h5A5A11);
        check("R6", pix_out, 24'h5A5A21);

        // R9 / R10 saturation corners in the blink phase
        cfg_bypass = 1'b1; cfg_op = 2'd2;
        step(1'b0, 1'b1, 24'hFF8000);
        check("R9", pix_out, 24'hFFC000);
        cfg_op = 2'd3; cfg_bkgnd = 24'h80FF01;
        step(1'b0, 1'b1, 24'h80017F);
        check("R10", pix_out, 24'hFFFF80);
        cfg_op = 2'd0;
        step(1'b0, 1'b1, 24'h123456);
        check("R7", pix_out, 24'h80FF01);
        cfg_op = 2'd1;
        step(1'b0, 1'b1, 24'hFF0281);
        check("R8", pix_out, 24'h7F0140);

        // R3: dropping the rate to 0 clears the phase
        cfg_rate = 8'd0;
        step(1'b0, 1'b1, 24'h111111);
        step(1'b1, 1'b1, 24'h222222);

        // random mix
        for (int i = 0; i < 600; i++) begin
            if (i % 50 == 0) cfg_rate = 8'($urandom_range(0, 3));
            cfg_bypass = 1'($urandom_range(0, 1));
            cfg_op = 2'($urandom_range(0, 3));
            cfg_mask = 8'($urandom);
            cfg_bkgnd = 24'($urandom);
            step(($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)), 24'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule